// File: doc/BRIEF.md
# Bus Inactivity Monitor

This block watches the transaction-valid signals of bus masters that must stay silent and raises an error when any of them goes active. It serves two cases. The first is the checker core of a lockstep pair, whose requests must never reach the interconnect because all system traffic goes through the main core. The second is a bus master inside a power domain that has been switched off and isolated.

Each monitored source has its own group of request signals and its own enable. The enable comes from the lockstep mode or from the power-off state of the domain. Every source runs a small state machine:

- `ST_IDLE`: the source is not monitored.
- `ST_ARM`: a single blind cycle after the enable rises, so that glitches during the power-down transition are ignored.
- `ST_WATCH`: monitoring is active.
- `ST_FAULT`: an error has been seen and is latched.

Transitions:

- Any state goes to `ST_IDLE` when the enable is low.
- `ST_IDLE` goes to `ST_ARM` when the enable is high.
- `ST_ARM` goes to `ST_WATCH` on the next cycle.
- `ST_WATCH` goes to `ST_FAULT` when a request bit or the force input is high.
- `ST_FAULT` holds its state.

The per-source errors are combined by OR into a single error output. A force input per source injects an error into the same path for self-test.

Top module: `bus_inactivity_monitor`

## Requirements
- R1: While reset is low, every `src_err` bit and `any_err` are 0, whatever the enables, requests or force inputs are.
- R2: A source whose enable was low at a clock edge shows `src_err` = 0 after that edge, whatever its request and force bits are.
- R3: In `ST_WATCH`, any request bit of the source at 1 at a clock edge makes that source's `src_err` 1 after the edge. The source's request bits are `req_i[s*SIG_W +: SIG_W]`.
- R4: Request bits sampled at the first edge after the enable rises are ignored, and the source's `src_err` stays 0 for two edges after the rise.
- R5: Once set, `src_err` stays 1 for as long as the source's enable stays high, even after its requests return to 0.
- R6: Taking a source's enable low clears that source's latched `src_err` at the next edge.
- R7: A source's `force_err` bit at 1 in `ST_WATCH` sets that source's `src_err` after the edge.
- R8: `any_err` is 1 exactly when at least one `src_err` bit is 1.
- R9: Sources are independent: activity or force on one source never sets another source's `src_err`.
- R10: `force_err` has no effect while a source is disabled or in its blind cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | NUM_SRC | Per-source monitor enable (lockstep on or domain off) |
| req_i | input | NUM_SRC*SIG_W | Monitored transaction-valid signals, SIG_W per source |
| force_err | input | NUM_SRC | Per-source self-test error injection |
| src_err | output | NUM_SRC | Latched per-source error |
| any_err | output | 1 | OR of all per-source errors |

## Verification
The bench sweeps every combination of the request pattern applied in the blind cycle and the pattern applied in the first watched cycle, for each source.

- A design without the blind cycle would flag glitches during the transition.
- A design that reduces only some request bits would miss patterns.
- A design that fails to latch would lose the error once the requests fall.

Further tests drive force while a source is disabled and during its blind cycle, where a design with a badly gated force would trip. A source that is kept disabled with all of its requests high must stay quiet, and each source is faulted on its own while the other is watched, so that any crosstalk between sources is caught.

// File: rtl/bim_pkg.sv
`timescale 1ns/1ps
package bim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_WATCH = 2'd2,
        ST_FAULT = 2'd3
    } mon_state_e;
endpackage

// File: rtl/bim_activity_detect.sv
`timescale 1ns/1ps
// Reduces one source's request group to a single activity flag.
module bim_activity_detect #(
    parameter int SIG_W = 8
) (
    input  logic [SIG_W-1:0] req,
    output logic             active
);
    always_comb begin
        active = |req;
    end
endmodule

// File: rtl/bim_src_fsm.sv
`timescale 1ns/1ps
// Per-source state machine: idle, one blind cycle, watch, latched fault.
module bim_src_fsm
    import bim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic active,
    input  logic force_err,
    output logic err,
    output logic watching
);
    mon_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ARM;
                ST_ARM:   state_d = ST_WATCH;
                ST_WATCH: if (active || force_err) state_d = ST_FAULT;
                ST_FAULT: state_d = ST_FAULT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        err      = 1'b0;
        watching = 1'b0;
        unique case (state_q)
            ST_WATCH: watching = 1'b1;
            ST_FAULT: err      = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bus_inactivity_monitor.sv
`timescale 1ns/1ps
module bus_inactivity_monitor #(
    parameter int NUM_SRC = 4,
    parameter int SIG_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       mon_en,
    input  logic [NUM_SRC*SIG_W-1:0] req_i,
    input  logic [NUM_SRC-1:0]       force_err,
    output logic [NUM_SRC-1:0]       src_err,
    output logic                     any_err
);
    localparam int REQ_W = NUM_SRC * SIG_W;

    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] watching;
    logic [REQ_W-1:0]   req_flat;

    assign req_flat = req_i;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        bim_activity_detect #(.SIG_W(SIG_W)) u_det (
            .req    (req_flat[s*SIG_W +: SIG_W]),
            .active (active[s])
        );
        bim_src_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (mon_en[s]),
            .active    (active[s]),
            .force_err (force_err[s]),
            .err       (src_err[s]),
            .watching  (watching[s])
        );
    end

    always_comb begin
        any_err = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) any_err = any_err | src_err[s];
    end
endmodule

// File: rtl/bim_checker.sv
`timescale 1ns/1ps
module bim_checker #(
    parameter int NUM_SRC = 4,
    parameter int SIG_W   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       mon_en,
    input logic [NUM_SRC*SIG_W-1:0] req_i,
    input logic [NUM_SRC-1:0]       force_err,
    input logic [NUM_SRC-1:0]       src_err,
    input logic                     any_err,
    input logic [NUM_SRC-1:0]       watching
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !mon_en[i] |=> !src_err[i]); // R2
        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            src_err[i] && mon_en[i] |=> src_err[i]); // R5
        AST_ARM_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mon_en[i]) ##1 mon_en[i] |=> !src_err[i]); // R4
        AST_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
            watching[i] && mon_en[i] && (|req_i[i*SIG_W +: SIG_W]) |=> src_err[i]); // R3
        AST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
            watching[i] && mon_en[i] && force_err[i] |=> src_err[i]); // R7
        AST_ANY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
            src_err[i] |-> any_err); // R8
    end
endmodule

bind bus_inactivity_monitor bim_checker #(.NUM_SRC(NUM_SRC), .SIG_W(SIG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_en    (mon_en),
    .req_i     (req_i),
    .force_err (force_err),
    .src_err   (src_err),
    .any_err   (any_err),
    .watching  (watching)
);

// File: tb/sim_bus_inactivity_monitor.sv
`timescale 1ns/1ps
module sim_bus_inactivity_monitor;
    localparam int NS = 2;
    localparam int SW = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NS-1:0]    mon_en;
    logic [NS*SW-1:0] req_i;
    logic [NS-1:0]    force_err;
    logic [NS-1:0]    src_err;
    logic             any_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_inactivity_monitor #(.NUM_SRC(NS), .SIG_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .req_i(req_i),
        .force_err(force_err), .src_err(src_err), .any_err(any_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // all other sources' request bits held high, source s gets val
    function automatic logic [NS*SW-1:0] fill(input int s, input int val);
        logic [NS*SW-1:0] v;
        v = '1;
        v[s*SW +: SW] = val[SW-1:0];
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; mon_en = '1; req_i = '1; force_err = '1;
        @(negedge clk);
        repeat (3) tick();
        chk("R1 src_err in reset", int'(src_err), 0);
        chk("R1 any_err in reset", int'(any_err), 0);
        rst_n = 1'b1; mon_en = '0; force_err = '0;
        tick();

        // R2 / R10: disabled sources with full activity and force
        force_err = '1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R2 disabled quiet", int'(src_err), 0);
            chk("R10 force while disabled", int'(any_err), 0);
        end
        force_err = '0;

        // sweep blind-cycle pattern q and first watched pattern p per source
        for (int s = 0; s < NS; s++) begin
            for (int q = 0; q < (1 << SW); q++) begin
                for (int p = 0; p < (1 << SW); p++) begin
                    mon_en = '0; req_i = fill(s, 0);
                    tick();
                    chk("R6 cleared on disable", int'(src_err[s]), 0);
                    mon_en[s] = 1'b1;
                    tick();
                    req_i = fill(s, q);
                    tick();
                    chk("R4 blind cycle", int'(src_err[s]), 0);
                    req_i = fill(s, p);
                    tick();
                    chk("R3 detect", int'(src_err[s]), int'(p != 0));
                    chk("R8 any_err", int'(any_err), int'(p != 0));
                    chk("R2 other source quiet", int'(src_err[1-s]), 0);
                    req_i = fill(s, 0);
                    tick();
                    chk("R5 latched", int'(src_err[s]), int'(p != 0));
                end
            end
        end

        // R7 / R10 force path
        mon_en = '0; req_i = '0; force_err = '0;
        tick();
        force_err[0] = 1'b1;
        tick();
        chk("R10 force disabled", int'(src_err[0]), 0);
        mon_en[0] = 1'b1;
        tick();
        tick();
        chk("R10 force in blind cycle", int'(src_err[0]), 0);
        force_err[0] = 1'b0;
        tick();
        chk("R7 watching no force", int'(src_err[0]), 0);
        force_err[0] = 1'b1;
        tick();
        chk("R7 force sets error", int'(src_err[0]), 1);
        chk("R8 any_err on force", int'(any_err), 1);
        force_err[0] = 1'b0;
        tick();
        chk("R5 forced error latched", int'(src_err[0]), 1);

        // R9 independence, R6 clearing of one source
        mon_en = '0;
        tick();
        mon_en = '1;
        tick();
        tick();
        req_i[1*SW +: SW] = 3'b100;
        tick();
        chk("R9 source1 faulted", int'(src_err[1]), 1);
        chk("R9 source0 untouched", int'(src_err[0]), 0);
        req_i = '0;
        mon_en[1] = 1'b0;
        tick();
        chk("R6 source1 cleared", int'(src_err[1]), 0);
        chk("R8 any_err cleared", int'(any_err), 0);

        finish_run();
    end
endmodule